// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block wraps the two ends of a 36-bit datapath that carries four 9-bit lanes, each lane being eight data bits plus one parity bit. On the way in, an optional generator works out the parity of each lane's eight data bits and writes the result over that lane's parity bit. The data bits pass through unchanged. On the way out, a checker tests all four complete lanes of every word that is read and raises a single registered error flag if any lane is wrong.

A two-bit configuration register sets odd or even parity and switches generation on or off. It is written with a one-cycle strobe. Generator and checker share the same odd/even setting, so a word that the generator has stamped always passes the check. The storage between the two sides is outside this block. The write path is combinational. The read path registers the word and its flag together, so the flag always describes the word currently shown at the output.

Top module: `byte_parity_unit`

## Requirements
- R1: After reset the configuration is generation off and odd parity, `rd_data_out` is zero and `rd_par_err` is low.
- R2: With generation off, `wr_data_out` equals `wr_data_in` bit for bit.
- R3: With generation on and odd parity, each lane's parity bit on `wr_data_out` is set so that the lane's nine bits hold an odd number of ones. All data bits are copied unchanged.
- R4: With generation on and even parity, each lane's parity bit is set so that the lane's nine bits hold an even number of ones.
- R5: Lane k (k = 0..3) has its data in bits 9k+7 down to 9k and its parity bit at 9k+8, so the parity bits are 8, 17, 26 and 35.
- R6: On a clock edge with `rd_en` high, `rd_data_out` takes `rd_data_in`. In the same cycle `rd_par_err` goes high exactly when some lane of that word has the wrong ones-count for the current odd/even setting. A word that the generator has stamped under the same setting never raises the flag.
- R7: One flag covers the whole word: an error in any single lane, whichever lane it is, raises `rd_par_err`.
- R8: While `rd_en` is low, `rd_data_out` and `rd_par_err` keep their values, whatever is on `rd_data_in`.
- R9: A strobe on `cfg_we` loads `cfg_wdata` (bit 0 = generation enable, bit 1 = even parity select) at the clock edge. The new setting is used by both sides from the next cycle.
- R10: While `cfg_we` is low, changes on `cfg_wdata` have no effect on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register and the read side |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Configuration value: bit 0 generation enable, bit 1 even select |
| wr_data_in | input | 36 | Word arriving on the write side |
| wr_data_out | output | 36 | Word with parity bits stamped when generation is on |
| rd_en | input | 1 | Read strobe: capture and check `rd_data_in` |
| rd_data_in | input | 36 | Word arriving on the read side |
| rd_data_out | output | 36 | Registered word presented to the reader |
| rd_par_err | output | 1 | Registered parity error flag for `rd_data_out` |

## Verification
The bench targets the all-zero and all-one words, where the odd and even settings give opposite parity bits. A design with the sense inverted, or with the setting ignored, produces wrong bits here. It flips one bit in each lane in turn. A checker that drops a lane, or that looks at the wrong bit positions, leaves the flag low for that lane. It also checks that a stamped word passes the check on the read side. It offers a bad word with `rd_en` low and moves `cfg_wdata` without a strobe. A design that captures data without the read strobe, or that latches configuration without the write strobe, changes what the ports show.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    localparam int LANES     = 4;
    localparam int DATA_BITS = 8;
    localparam int LANE_W    = DATA_BITS + 1;
    localparam int WORD_W    = LANES * LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;

    // Packed so that bit 0 is gen_en and bit 1 is even_sel.
    typedef struct packed {
        logic even_sel;
        logic gen_en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{even_sel: 1'b0, gen_en: 1'b0};

    // Bit that completes a lane to the selected parity sense.
    function automatic logic stamp_bit(input logic [DATA_BITS-1:0] d, input logic even_sel);
        return (^d) ^ ~even_sel;
    endfunction

    // A lane is wrong when its ones-count parity equals even_sel:
    // odd sense needs XOR 1, even sense needs XOR 0.
    function automatic logic lane_wrong(input lane_t l, input logic even_sel);
        return (^l) == even_sel;
    endfunction

endpackage

// File: rtl/bpg_cfg_reg.sv
module bpg_cfg_reg
    import bpg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cfg_t wdata,
    output cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RESET;
        else if (we)
            cfg <= wdata;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg)) else $error("cfg changed without strobe"); // R10

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> cfg == $past(wdata)) else $error("cfg not loaded"); // R9

endmodule

// File: rtl/bpg_gen.sv
module bpg_gen
    import bpg_pkg::*;
#(
    parameter int NUM_LANES = LANES,
    localparam int W = NUM_LANES * LANE_W
) (
    input  cfg_t         cfg,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int BASE = k * LANE_W;
        logic [DATA_BITS-1:0] data;
        assign data = din[BASE +: DATA_BITS];
        assign dout[BASE +: DATA_BITS] = data;
        assign dout[BASE + DATA_BITS] = cfg.gen_en ? stamp_bit(data, cfg.even_sel)
                                                   : din[BASE + DATA_BITS];
    end

endmodule

// File: rtl/bpg_check.sv
module bpg_check
    import bpg_pkg::*;
#(
    parameter int NUM_LANES = LANES,
    localparam int W = NUM_LANES * LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cfg_t         cfg,
    input  logic         rd_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         err
);

    logic [NUM_LANES-1:0] wrong;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        assign wrong[k] = lane_wrong(din[k*LANE_W +: LANE_W], cfg.even_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            err  <= 1'b0;
        end else if (rd_en) begin
            dout <= din;
            err  <= |wrong;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(dout) && $stable(err)) else $error("read side moved"); // R8

    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> dout == $past(din)) else $error("word not captured"); // R6

endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
    import bpg_pkg::*;
#(
    parameter int NUM_LANES = LANES,
    localparam int W = NUM_LANES * LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_wdata,
    input  logic [W-1:0] wr_data_in,
    output logic [W-1:0] wr_data_out,
    input  logic         rd_en,
    input  logic [W-1:0] rd_data_in,
    output logic [W-1:0] rd_data_out,
    output logic         rd_par_err
);

    cfg_t cfg;

    bpg_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_t'(cfg_wdata)),
        .cfg   (cfg)
    );

    bpg_gen #(.NUM_LANES(NUM_LANES)) u_gen (
        .cfg  (cfg),
        .din  (wr_data_in),
        .dout (wr_data_out)
    );

    bpg_check #(.NUM_LANES(NUM_LANES)) u_chk (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .rd_en (rd_en),
        .din   (rd_data_in),
        .dout  (rd_data_out),
        .err   (rd_par_err)
    );

    logic [W-1:0] data_mask;
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_mask
        assign data_mask[k*LANE_W +: LANE_W] = {1'b0, {DATA_BITS{1'b1}}};
    end

    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_data_out & data_mask) == (wr_data_in & data_mask)) else $error("data bits altered"); // R3

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        !cfg.gen_en |-> wr_data_out == wr_data_in) else $error("pass-through broken"); // R2

    AST_LOOPBACK: assert property (@(posedge clk) disable iff (rst)
        cfg.gen_en && rd_en && (rd_data_in == wr_data_out) |=> !rd_par_err) else $error("stamped word failed"); // R6

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_par_err && rd_data_out == '0) else $error("reset state"); // R1

endmodule

// File: tb/test_byte_parity_unit.sv
module test_byte_parity_unit;

    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_wdata = 2'b00;
    logic [W-1:0] wr_data_in = '0;
    logic [W-1:0] wr_data_out;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data_in = '0;
    logic [W-1:0] rd_data_out;
    logic         rd_par_err;

    always #4 clk = ~clk;

    byte_parity_unit i_byte_parity_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wr_data_in(wr_data_in), .wr_data_out(wr_data_out),
        .rd_en(rd_en), .rd_data_in(rd_data_in),
        .rd_data_out(rd_data_out), .rd_par_err(rd_par_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Vector: cfg (bit0 gen, bit1 even), data word
    typedef struct packed { logic [1:0] cfg; logic [W-1:0] data; } vec_t;
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 36'h1_2345_6789},
        '{2'b10, 36'h0_0000_0000},
        '{2'b01, 36'h0_0000_0000},
        '{2'b11, 36'h0_0000_0000},
        '{2'b01, 36'hF_FFFF_FFFF},
        '{2'b11, 36'hF_FFFF_FFFF},
        '{2'b11, 36'hA_5A5A_5A5A},
        '{2'b01, 36'h0_FF0F_F0FF},
        '{2'b01, 36'h7_3C01_8E42},
        '{2'b11, 36'h5_0201_8000}
    };

    function automatic logic [W-1:0] model_gen(input logic [1:0] c, input logic [W-1:0] d);
        logic [W-1:0] r = d;
        if (c[0])
            for (int k = 0; k < 4; k++) begin
                int ones = $countones(d[k*9 +: 8]);
                r[k*9+8] = c[1] ? ones[0] : ~ones[0];
            end
        return r;
    endfunction

    function automatic logic model_err(input logic even, input logic [W-1:0] d);
        logic e = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int ones = $countones(d[k*9 +: 9]);
            if (ones[0] != ~even) e = 1'b1;
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [1:0] c);
        cfg_we = 1'b1; cfg_wdata = c;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic do_read(input logic [W-1:0] d);
        rd_data_in = d; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        logic [W-1:0] g, bad;
        tick(); tick();
        rst = 1'b0;
        #1;
        // R1: reset state, gen off visible as pass-through
        check(rd_data_out == '0, "R1 rd_data_out", rd_data_out, '0);
        check(rd_par_err == 1'b0, "R1 rd_par_err", W'(rd_par_err), '0);
        wr_data_in = 36'h0_0000_0000; #1;
        check(wr_data_out == wr_data_in, "R1 gen off", wr_data_out, wr_data_in);
        // R1: odd default: zero word fails the check
        do_read(36'h0);
        check(rd_par_err == 1'b1, "R1 odd default", W'(rd_par_err), W'(1));

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            vec_t v = VEC[i];
            set_cfg(v.cfg);
            wr_data_in = v.data; #1;
            g = model_gen(v.cfg, v.data);
            check(wr_data_out == g, v.cfg[0] ? (v.cfg[1] ? "R4 gen even" : "R3 gen odd") : "R2 pass",
                  wr_data_out, g);
            do_read(v.data);
            check(rd_data_out == v.data, "R6 capture", rd_data_out, v.data);
            check(rd_par_err == model_err(v.cfg[1], v.data), "R6 flag raw", W'(rd_par_err),
                  W'(model_err(v.cfg[1], v.data)));
            do_read(g);
            check(rd_par_err == model_err(v.cfg[1], g), "R9 flag stamped", W'(rd_par_err),
                  W'(model_err(v.cfg[1], g)));
        end

        // R5 R7: single-bit error in each lane, data bit and parity bit positions
        set_cfg(2'b01);
        wr_data_in = 36'h3_1C2B_4D5E; #1;
        g = wr_data_out;
        do_read(g);
        check(rd_par_err == 1'b0, "R6 clean word", W'(rd_par_err), '0);
        for (int k = 0; k < 4; k++) begin
            bad = g; bad[k*9 + 8] = ~bad[k*9 + 8];
            do_read(bad);
            check(rd_par_err == 1'b1, "R7 parity bit lane", W'(rd_par_err), W'(1));
            bad = g; bad[k*9 + 3] = ~bad[k*9 + 3];
            do_read(bad);
            check(rd_par_err == 1'b1, "R5 data bit lane", W'(rd_par_err), W'(1));
            do_read(g);
            check(rd_par_err == 1'b0, "R7 recover", W'(rd_par_err), '0);
        end

        // R8: bad word offered without rd_en
        rd_data_in = 36'h0; rd_en = 1'b0;
        tick(); tick();
        check(rd_data_out == g, "R8 data hold", rd_data_out, g);
        check(rd_par_err == 1'b0, "R8 flag hold", W'(rd_par_err), '0);

        // R10: cfg_wdata moves without strobe; gen stays on odd
        cfg_we = 1'b0; cfg_wdata = 2'b10;
        tick(); tick();
        wr_data_in = 36'h0; #1;
        check(wr_data_out == 36'h8_0402_0100, "R10 cfg ignored", wr_data_out, 36'h8_0402_0100);

        // R9: strobe to even takes effect next cycle on both sides
        set_cfg(2'b11);
        #1;
        check(wr_data_out == 36'h0, "R9 gen even", wr_data_out, 36'h0);
        do_read(36'h0);
        check(rd_par_err == 1'b0, "R9 check even", W'(rd_par_err), '0);

        // R1: reset in mid-run restores gen off / odd
        rst = 1'b1; tick(); rst = 1'b0; #1;
        wr_data_in = 36'h0_0000_0000; #1;
        check(wr_data_out == 36'h0, "R1 reset gen off", wr_data_out, 36'h0);
        check(rd_data_out == '0 && !rd_par_err, "R1 reset read", rd_data_out, '0);
        do_read(36'h0);
        check(rd_par_err == 1'b1, "R1 reset odd", W'(rd_par_err), W'(1));

        finish_run();
    end

endmodule